// File: doc/BRIEF.md
# Pipelined Converter Code Aligner and Corrector

This block turns the coarse decisions of a nine-stage pipelined analog-to-digital converter into one 10-bit sample per clock. Eight redundant stages each report a 2-bit decision in the range 0 to 2, where the third level is the redundancy that absorbs comparator offsets. A final flash stage reports a plain 2-bit value. Later stages resolve the same analog sample later than earlier ones, so on any single clock the nine inputs belong to different samples. The block delays each stage's code so that the codes of one sample meet, and then forms the weighted sum of the aligned codes to get the binary result.

The corrected word leaves on a registered output with a valid flag. The stream has no ready input because a converter cannot be stalled: after the fill period the block produces one sample on every clock and the consumer must accept it. A sticky flag reports any redundant stage that presented the unused code 2'b11.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Redundant stage k (k = 1..8) is read from `red_code_i[2k-1:2k-2]`. Its code for a sample is presented floor(k/2) cycles after stage 1's code for that sample, and the flash code is presented 4 cycles after stage 1's code. The corrected word for that sample is on `sample_o` one cycle after its flash code was presented.
- R2: The corrected word equals the sum over k = 1..8 of code_k × 2^(9-k), plus the flash code, as an unsigned 10-bit number.
- R3: A redundant stage code of 2'b11 enters the sum as if it were 2'b10.
- R4: A 2'b11 code on any redundant stage input sets `code_err_o` one cycle later, and the flag stays high until reset.
- R5: `sample_valid_o` is low for the first 5 clock edges after reset is released and high on every cycle from then on.
- R6: While reset is asserted (active low, asynchronous), `sample_o` is 0, `sample_valid_o` is 0 and `code_err_o` is 0.
- R7: The extreme code sets map to the extreme outputs: all codes 0 give 0, and all redundant codes 2'b10 with flash 2'b11 give 1023.
- R8: Legal codes (0, 1 and 2 on redundant stages, any flash value) never set `code_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| red_code_i | input | 16 | Codes of the eight redundant stages, stage k in bits [2k-1:2k-2] |
| flash_code_i | input | 2 | Code of the final flash stage |
| sample_o | output | 10 | Corrected sample |
| sample_valid_o | output | 1 | High once the alignment delays hold real data |
| code_err_o | output | 1 | Sticky flag for an illegal redundant code |

## Verification
The stage codes come from an ideal quantizer applied to random 10-bit input values. In the default mode each stage decides at random between its two legal codes inside the redundancy margin, so the same value reaches the output through different code combinations, and only correct weights and correct alignment give the ideal word every time. Directed samples use the quantizer with every stage taking its higher choice and with every stage taking its lower choice, which separates a mistake in the overlap from a mistake in the alignment. The extreme values 0 and 1023 exercise the range ends. A single late sample carries 2'b11 on one stage to check the clamped sum and the sticky error flag.

// File: rtl/adc_ec_pkg.sv
package adc_ec_pkg;

  typedef logic [1:0] code_t;

  // largest decision a redundant stage may report
  localparam code_t RED_CODE_TOP = 2'b10;

  function automatic code_t clamp_code(input code_t c);
    return (c > RED_CODE_TOP) ? RED_CODE_TOP : c;
  endfunction

  function automatic logic is_bad_code(input code_t c);
    return c == 2'b11;
  endfunction

endpackage

// File: rtl/adc_ec_delay.sv
module adc_ec_delay #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] taps [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
    end else begin
      taps[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  assign q_o = taps[DEPTH-1];

endmodule

// File: rtl/adc_ec_sum.sv
module adc_ec_sum
  import adc_ec_pkg::*;
#(
  parameter int N_RED = 8,
  localparam int OUT_W = N_RED + 2
) (
  input  logic [2*N_RED-1:0] red_i,
  input  code_t              flash_i,
  output logic [OUT_W-1:0]   sum_o
);

  // overlap-add: stage k (1-based) weighs 2^(N_RED+1-k), flash weighs 1
  always_comb begin
    logic [OUT_W-1:0] acc;
    acc = OUT_W'(flash_i);
    for (int k = 0; k < N_RED; k++) begin
      acc = acc + (OUT_W'(clamp_code(red_i[2*k +: 2])) << (N_RED - k));
    end
    sum_o = acc;
  end

endmodule

// File: rtl/adc_ec_fill.sv
module adc_ec_fill #(
  parameter int FILL = 5,
  localparam int CW = $clog2(FILL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic valid_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      if (cnt_q != CW'(FILL)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(FILL - 1)) valid_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import adc_ec_pkg::*;
#(
  parameter int N_RED = 8,
  localparam int OUT_W = N_RED + 2,
  localparam int LAST_SLOT = (N_RED + 1) / 2,
  localparam int FILL = LAST_SLOT + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*N_RED-1:0] red_code_i,
  input  logic [1:0]         flash_code_i,
  output logic [OUT_W-1:0]   sample_o,
  output logic               sample_valid_o,
  output logic               code_err_o
);

  logic [2*N_RED-1:0] aligned;
  logic [N_RED-1:0]   bad_vec;
  logic [OUT_W-1:0]   sum;

  // stage k arrives k/2 cycles after stage 1; pad it up to the flash slot
  for (genvar k = 1; k <= N_RED; k++) begin : g_stage
    localparam int DLY = LAST_SLOT - k / 2;
    if (DLY == 0) begin : g_pass
      assign aligned[2*(k-1) +: 2] = red_code_i[2*(k-1) +: 2];
    end else begin : g_dly
      adc_ec_delay #(.WIDTH(2), .DEPTH(DLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (red_code_i[2*(k-1) +: 2]),
        .q_o   (aligned[2*(k-1) +: 2])
      );
    end
    assign bad_vec[k-1] = is_bad_code(red_code_i[2*(k-1) +: 2]);
  end

  adc_ec_sum #(.N_RED(N_RED)) u_sum (
    .red_i   (aligned),
    .flash_i (flash_code_i),
    .sum_o   (sum)
  );

  adc_ec_fill #(.FILL(FILL)) u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_o (sample_valid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o   <= '0;
      code_err_o <= 1'b0;
    end else begin
      sample_o   <= sum;
      code_err_o <= code_err_o | (|bad_vec);
    end
  end

endmodule

// File: rtl/pipe_adc_corrector_chk.sv
module pipe_adc_corrector_chk #(
  parameter int N_RED = 8,
  localparam int OUT_W = N_RED + 2,
  localparam int FILL = (N_RED + 1) / 2 + 1,
  localparam int CW = $clog2(FILL + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*N_RED-1:0] red_code_i,
  input logic [1:0]         flash_code_i,
  input logic [OUT_W-1:0]   sample_o,
  input logic               sample_valid_o,
  input logic               code_err_o
);

  logic [CW-1:0] edges_q;
  logic          bad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges_q <= '0;
    else if (edges_q != CW'(FILL)) edges_q <= edges_q + 1'b1;
  end

  always_comb begin
    bad_in = 1'b0;
    for (int k = 0; k < N_RED; k++) bad_in |= (red_code_i[2*k +: 2] == 2'b11);
  end

  p_no_early_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q < CW'(FILL)) |-> !sample_valid_o);

  p_valid_after_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == CW'(FILL)) |-> sample_valid_o);

  p_valid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |=> sample_valid_o);

  p_bad_code_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_in |=> code_err_o);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_err_o |=> code_err_o);

  p_no_false_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_err_o && !bad_in) |=> !code_err_o);

  // only the flash code has weight 1, so the LSB follows it by one cycle (R1, R2)
  p_lsb_from_flash_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |-> (sample_o[0] == $past(flash_code_i[0])));

endmodule

bind pipe_adc_corrector pipe_adc_corrector_chk #(.N_RED(N_RED)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .red_code_i     (red_code_i),
  .flash_code_i   (flash_code_i),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o),
  .code_err_o     (code_err_o)
);

// File: tb/pipe_adc_corrector_tb.sv
`timescale 1ns/1ps
module pipe_adc_corrector_tb;

  localparam int NS    = 3000;
  localparam int S_BAD = NS - 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] red_code_i = '0;
  logic [1:0]  flash_code_i = '0;
  logic [9:0]  sample_o;
  logic        sample_valid_o;
  logic        code_err_o;

  int checks = 0;
  int errors = 0;

  logic [1:0] cod [NS][9];
  int         expv [NS];

  always #2 clk = ~clk;

  pipe_adc_corrector u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .red_code_i     (red_code_i),
    .flash_code_i   (flash_code_i),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o),
    .code_err_o     (code_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ideal stage quantizer; mode 0 random choice, 1 upper choice, 2 lower choice
  task automatic quant(input int s, input int x, input int mode);
    int r;
    r = x;
    for (int k = 1; k <= 8; k++) begin
      int w, d;
      w = 1 << (9 - k);
      d = r / w;
      if (d > 2) d = 2;
      else if (d >= 1) begin
        if (mode == 2 || (mode == 0 && ($urandom % 2) == 1)) d = d - 1;
      end
      r = r - d * w;
      cod[s][k-1] = 2'(d);
    end
    cod[s][8] = 2'(r);
  endtask

  // R2/R3 arithmetic: weighted sum with 2'b11 counted as 2'b10
  function automatic int ref_sum(input int s);
    int acc;
    acc = int'(cod[s][8]);
    for (int k = 1; k <= 8; k++) begin
      int c;
      c = int'(cod[s][k-1]);
      if (c == 3) c = 2;
      acc += c << (9 - k);
    end
    return acc;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < NS; s++) begin
      int x, mode;
      x = int'($urandom % 1024);
      mode = 0;
      if (s == 0) x = 0;
      if (s == 1) begin x = 1023; mode = 1; end
      if (s == 2) begin x = 700; mode = 2; end
      if (s == 3) begin x = 341; mode = 1; end
      if (s == 4) begin x = 1023; mode = 2; end
      quant(s, x, mode);
      expv[s] = x;
    end
    // R7 explicit extreme code sets
    for (int k = 0; k < 8; k++) begin cod[0][k] = 2'b00; cod[1][k] = 2'b10; end
    cod[0][8] = 2'b00;
    cod[1][8] = 2'b11;
    // R3 illegal code on stage 3
    cod[S_BAD][2] = 2'b11;
    expv[S_BAD] = ref_sum(S_BAD);

    repeat (3) @(negedge clk);
    chk(sample_o == 10'd0, "R6 sample", int'(sample_o), 0);
    chk(sample_valid_o == 1'b0, "R6 valid", int'(sample_valid_o), 0);
    chk(code_err_o == 1'b0, "R6 err", int'(code_err_o), 0);

    for (int c = 0; c < NS + 6; c++) begin
      @(negedge clk);
      if (c == 0) rst_n = 1'b1;
      chk(sample_valid_o == (c >= 5), "R5 valid", int'(sample_valid_o), int'(c >= 5));
      if (c >= 5 && c - 5 < NS) begin
        int s;
        s = c - 5;
        if (s < 2)
          chk(int'(sample_o) == expv[s], "R7 extreme", int'(sample_o), expv[s]);
        else if (s == S_BAD)
          chk(int'(sample_o) == expv[s], "R3 clamp", int'(sample_o), expv[s]);
        else
          chk(int'(sample_o) == expv[s], "R1 R2 sample", int'(sample_o), expv[s]);
      end
      if (c < S_BAD + 2)
        chk(code_err_o == 1'b0, "R8 no flag", int'(code_err_o), 0);
      else
        chk(code_err_o == 1'b1, "R4 sticky flag", int'(code_err_o), 1);
      // drive inputs for this cycle
      for (int k = 1; k <= 8; k++) begin
        int idx;
        idx = c - k / 2;
        red_code_i[2*(k-1) +: 2] = (idx >= 0 && idx < NS) ? cod[idx][k-1] : 2'b00;
      end
      flash_code_i = (c - 4 >= 0 && c - 4 < NS) ? cod[c-4][8] : 2'b00;
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sample_o == 10'd0, "R6 sample after reset", int'(sample_o), 0);
    chk(sample_valid_o == 1'b0, "R6 valid after reset", int'(sample_valid_o), 0);
    chk(code_err_o == 1'b0, "R4 flag cleared by reset", int'(code_err_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule